// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block is an 8-bit timer/counter that shares one 8-bit prescaler with a watchdog timeout path. The timer counts either instruction-cycle ticks or edges of an external pin. Edges on the pin are synchronized into the clock domain and qualified by a selectable polarity. The prescaler belongs to exactly one owner at a time. When the timer owns it, the timer's count events are divided by a power of two. When the watchdog owns it, it divides the watchdog oscillator ticks into timeout pulses, and the timer then counts every event undivided.

A 6-bit option word, loaded through its own write strobe, holds four fields: the clock source, the edge polarity, the prescaler owner and a 3-bit rate. The rate drives an eight-way tap multiplexer on the prescaler. Software may load the timer at any time. A load clears the prescaler when the timer owns it and holds off counting for two instruction cycles, so that a freshly written value is not disturbed at once.

Top module: `tsp_timer_unit`

## Requirements
- R1: Option bit 3 picks the prescaler owner (1 = watchdog, 0 = timer). With the watchdog owning it, the timer advances once per selected event with no division, and timer events leave the prescaler count untouched. With the timer owning it, every watchdog tick yields a timeout pulse, and watchdog ticks leave the prescaler untouched.
- R2: With the timer owning the prescaler and rate field bits [2:0] = n, the timer advances once per 2^(n+1) selected events, counted from a cleared prescaler.
- R3: With the watchdog owning the prescaler and rate n, `wdt_timeout` pulses once per 2^n watchdog ticks, counted from a cleared prescaler. Each pulse is one cycle wide and comes one cycle after the tick that caused it.
- R4: Option bit 5 selects the count source (1 = external pin edges, 0 = `cyc_tick`). The source that is not selected has no effect on the timer.
- R5: Option bit 4 selects the pin polarity (0 = rising edges, 1 = falling edges). Edges of the other polarity are ignored.
- R6: The pin passes through two synchronizer flops before edge detection. A pin change made ahead of clock edge k shows in `tmr_value` after edge k+2 and not earlier.
- R7: Reset sets the timer to 00h and all option bits to 1: pin source, falling edge, watchdog owns the prescaler, rate 7.
- R8: A timer write loads `tmr_wdata`. When the timer owns the prescaler, the write also clears it. Events arriving during the write and during the next two `cyc_tick` pulses are dropped.
- R9: The timer wraps from FFh to 00h.
- R10: Any option write clears the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cyc_tick | input | 1 | One-cycle pulse per instruction cycle |
| ext_pin | input | 1 | Asynchronous external count input |
| wdt_tick | input | 1 | One-cycle pulse per watchdog base period |
| opt_we | input | 1 | Option word write strobe |
| opt_wdata | input | 6 | Option word: [5] source, [4] polarity, [3] owner, [2:0] rate |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write value |
| tmr_value | output | 8 | Current timer count |
| wdt_timeout | output | 1 | Watchdog timeout pulse |

## Verification
The divided path is exercised by a sweep over every rate, once with pin pulses under each polarity and once with instruction ticks, each run with an event count that is not a multiple of the ratio. A wrong tap or a wrong power shows up as a differing quotient. Watchdog division is swept the same way, and the undivided timer count is checked alongside it to tell the two owners apart. Lone rising and lone falling pin edges separate the two polarities. A pin change followed cycle by cycle pins down the synchronizer depth. Partial prescaler counts interrupted by a timer write or an option write show whether the clear took effect. A load just below FFh, followed by single ticks, checks both the hold-off window and the wrap.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

   typedef enum logic {
      PSC_ON_TMR = 1'b0,
      PSC_ON_WDT = 1'b1
   } psc_owner_e;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } pin_edge_e;

   typedef enum logic {
      SRC_CYCLE = 1'b0,
      SRC_PIN   = 1'b1
   } count_src_e;

   // field offsets above the rate field, relative to the rate width
   localparam int unsigned OWNER_OFS = 0;
   localparam int unsigned EDGE_OFS  = 1;
   localparam int unsigned SRC_OFS   = 2;
   localparam int unsigned EXTRA_OPT = 3;

endpackage

// File: rtl/tsp_edge_sync.sv
module tsp_edge_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic evt
);
   localparam int unsigned SH_W = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tsp_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SH_W-1:0] sh_q;
   logic            cur, prev, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SH_W-2:0], pin};
   end

   assign cur  = sh_q[SYNC_STAGES-1];
   assign prev = sh_q[SYNC_STAGES];
   assign rise = cur & ~prev;
   assign fall = ~cur & prev;
   assign evt  = fall_sel ? fall : rise;

   // R5: one polarity cannot fire on two cycles in a row
   a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (!evt || fall_sel != $past(fall_sel)));

endmodule

// File: rtl/tsp_prescaler.sv
module tsp_prescaler #(
   parameter int unsigned PSC_W  = 8,
   parameter int unsigned RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              to_wdt,
   input  logic [RATE_W-1:0] rate,
   input  logic              tmr_evt,
   input  logic              wdt_tick,
   output logic              tmr_tick,
   output logic              wdt_out
);
   localparam int unsigned NTAP = 1 << RATE_W;

   if (NTAP > PSC_W) begin : g_bad_taps
      $error("tsp_prescaler: 2**RATE_W taps exceed PSC_W bits");
   end

   logic [PSC_W-1:0] cnt_q;
   logic [NTAP-1:0]  tap_tmr, tap_wdt;
   logic             adv, sel_tmr, sel_wdt;

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      assign tap_tmr[i] = &cnt_q[i:0];
      if (i == 0) begin : g_first
         assign tap_wdt[i] = 1'b1;
      end else begin : g_rest
         assign tap_wdt[i] = &cnt_q[i-1:0];
      end
   end

   assign adv     = to_wdt ? wdt_tick : tmr_evt;
   assign sel_tmr = tap_tmr[rate];
   assign sel_wdt = tap_wdt[rate];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (adv) cnt_q <= cnt_q + 1'b1;
   end

   assign tmr_tick = to_wdt ? tmr_evt : (tmr_evt & sel_tmr & ~clr);
   assign wdt_out  = to_wdt ? (wdt_tick & sel_wdt & ~clr) : wdt_tick;

   // R10: a clear request empties the count
   a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0);
   // R1: while owned by the watchdog, only watchdog ticks move the count
   a_r1_wdt_owner_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      to_wdt && !wdt_tick && !clr |=> $stable(cnt_q));
   // R1: while owned by the timer, watchdog ticks do not move the count
   a_r1_tmr_owner_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !to_wdt && !tmr_evt && !clr |=> $stable(cnt_q));

endmodule

// File: rtl/tsp_counter.sv
module tsp_counter #(
   parameter int unsigned TMR_W   = 8,
   parameter int unsigned INH_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [TMR_W-1:0] wdata,
   input  logic             cyc_tick,
   input  logic             inc,
   output logic [TMR_W-1:0] value,
   output logic             hold
);
   localparam int unsigned IW = $clog2(INH_CYC + 1);

   if (INH_CYC < 1) begin : g_bad_inh
      $error("tsp_counter: INH_CYC must be at least 1");
   end

   logic [IW-1:0]    inh_q;
   logic [TMR_W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         inh_q <= '0;
      else if (we)                        inh_q <= IW'(INH_CYC);
      else if (cyc_tick && inh_q != '0)   inh_q <= inh_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (we)  val_q <= wdata;
      else if (inc) val_q <= val_q + 1'b1;
   end

   assign value = val_q;
   assign hold  = we | (inh_q != '0);

   // R8: a write lands on the next cycle
   a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> val_q == $past(wdata));
   // R8: no movement while the hold-off window is open
   a_r8_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
      (inh_q != '0) && !we |=> $stable(val_q));
   // R9: top value wraps to zero
   a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q == '1) && inc && !we |=> val_q == '0);

endmodule

// File: rtl/tsp_timer_unit.sv
module tsp_timer_unit #(
   parameter int unsigned TMR_W       = 8,
   parameter int unsigned PSC_W       = 8,
   parameter int unsigned RATE_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned INH_CYC     = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cyc_tick,
   input  logic                  ext_pin,
   input  logic                  wdt_tick,
   input  logic                  opt_we,
   input  logic [RATE_W+2:0]     opt_wdata,
   input  logic                  tmr_we,
   input  logic [TMR_W-1:0]      tmr_wdata,
   output logic [TMR_W-1:0]      tmr_value,
   output logic                  wdt_timeout
);
   import tsp_pkg::*;

   localparam int unsigned OPT_W     = RATE_W + EXTRA_OPT;
   localparam int unsigned OWNER_BIT = RATE_W + OWNER_OFS;
   localparam int unsigned EDGE_BIT  = RATE_W + EDGE_OFS;
   localparam int unsigned SRC_BIT   = RATE_W + SRC_OFS;

   if (TMR_W < 2) begin : g_bad_tmr
      $error("tsp_timer_unit: TMR_W must be at least 2");
   end

   logic [OPT_W-1:0] opt_q;
   psc_owner_e       owner;
   pin_edge_e        pol;
   count_src_e       src;
   logic             to_wdt, pin_evt, raw_evt, gated_evt, hold;
   logic             tmr_tick, wdt_out, psc_clr, wdt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      opt_q <= '1;
      else if (opt_we) opt_q <= opt_wdata;
   end

   assign owner  = psc_owner_e'(opt_q[OWNER_BIT]);
   assign pol    = pin_edge_e'(opt_q[EDGE_BIT]);
   assign src    = count_src_e'(opt_q[SRC_BIT]);
   assign to_wdt = (owner == PSC_ON_WDT);

   tsp_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .fall_sel (pol == EDGE_FALL),
      .evt      (pin_evt)
   );

   assign raw_evt   = (src == SRC_PIN) ? pin_evt : cyc_tick;
   assign gated_evt = raw_evt & ~hold;
   assign psc_clr   = opt_we | (tmr_we & ~to_wdt);

   tsp_prescaler #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (psc_clr),
      .to_wdt   (to_wdt),
      .rate     (opt_q[RATE_W-1:0]),
      .tmr_evt  (gated_evt),
      .wdt_tick (wdt_tick),
      .tmr_tick (tmr_tick),
      .wdt_out  (wdt_out)
   );

   tsp_counter #(.TMR_W(TMR_W), .INH_CYC(INH_CYC)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (tmr_we),
      .wdata    (tmr_wdata),
      .cyc_tick (cyc_tick),
      .inc      (tmr_tick),
      .value    (tmr_value),
      .hold     (hold)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wdt_q <= 1'b0;
      else        wdt_q <= wdt_out;
   end
   assign wdt_timeout = wdt_q;

   // R3: every timeout follows a watchdog tick by one cycle
   a_r3_timeout_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_timeout |-> $past(wdt_tick));
   // R1: timer owner leaves the watchdog path undivided
   a_r1_wdt_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_tick && (owner == PSC_ON_TMR) |=> wdt_timeout);
   // R4: with the cycle source, no tick and no write means no change
   a_r4_cycle_src_only: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_CYCLE) && !cyc_tick && !tmr_we |=> $stable(tmr_value));

endmodule

// File: tb/tsp_timer_unit_test.sv
module tsp_timer_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_tick = 1'b0;
   logic       ext_pin = 1'b0;
   logic       wdt_tick = 1'b0;
   logic       opt_we = 1'b0;
   logic [5:0] opt_wdata = '0;
   logic       tmr_we = 1'b0;
   logic [7:0] tmr_wdata = '0;
   logic [7:0] tmr_value;
   logic       wdt_timeout;

   always #5 clk = ~clk;

   tsp_timer_unit uut (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
      .wdt_tick(wdt_tick), .opt_we(opt_we), .opt_wdata(opt_wdata),
      .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_value(tmr_value),
      .wdt_timeout(wdt_timeout)
   );

   typedef struct {
      string tag;
      bit    on_wdt;
      int    exp;
   } item_t;

   item_t q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   int    wdt_seen = 0;
   bit    done = 1'b0;

   always @(negedge clk) if (rst_n && wdt_timeout) wdt_seen++;

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         wait (q.size() > 0);
         #1;
         begin
            item_t it;
            int    got;
            it  = q.pop_front();
            got = it.on_wdt ? wdt_seen : int'(tmr_value);
            n_vec++;
            if (got != it.exp) begin
               n_bad++;
               $display("FAIL %s: got %0d expected %0d", it.tag, got, it.exp);
            end
         end
      end
   end

   task automatic expect_tmr(string tag, int v);
      item_t it;
      it.tag = tag; it.on_wdt = 1'b0; it.exp = v & 8'hFF;
      q.push_back(it);
      #2;
   endtask

   task automatic expect_wdt(string tag, int v);
      item_t it;
      it.tag = tag; it.on_wdt = 1'b1; it.exp = v;
      q.push_back(it);
      #2;
   endtask

   function automatic logic [5:0] mkopt(bit pin_src, bit fall, bit wdt_own, int rate);
      return {pin_src, fall, wdt_own, 3'(rate)};
   endfunction

   task automatic tick_cyc(int n);
      for (int i = 0; i < n; i++) begin
         cyc_tick = 1'b1; @(negedge clk);
         cyc_tick = 1'b0; @(negedge clk);
      end
   endtask

   task automatic tick_wdt(int n);
      for (int i = 0; i < n; i++) begin
         wdt_tick = 1'b1; @(negedge clk);
         wdt_tick = 1'b0; @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic pin_toggle();
      ext_pin = ~ext_pin;
      repeat (4) @(negedge clk);
   endtask

   task automatic pin_pulses(int n);
      for (int i = 0; i < n; i++) begin
         pin_toggle();
         pin_toggle();
      end
   endtask

   task automatic write_opt(logic [5:0] v);
      opt_wdata = v; opt_we = 1'b1; @(negedge clk);
      opt_we = 1'b0; @(negedge clk);
   endtask

   task automatic write_tmr_raw(logic [7:0] v);
      tmr_wdata = v; tmr_we = 1'b1; @(negedge clk);
      tmr_we = 1'b0;
   endtask

   task automatic write_tmr(logic [7:0] v);
      write_tmr_raw(v);
      @(negedge clk);
      tick_cyc(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_tmr("R7 reset timer", 0);

      // defaults: pin source, falling edge, watchdog owner, rate 7
      pin_toggle();
      expect_tmr("R7 R5 rising ignored by default", 0);
      pin_toggle();
      expect_tmr("R7 R1 falling counted undivided", 1);
      tick_cyc(3);
      expect_tmr("R4 cycle ticks ignored with pin source", 1);
      tick_wdt(127);
      expect_wdt("R7 R3 rate 7 below 128 ticks", 0);
      tick_wdt(1);
      expect_wdt("R7 R3 rate 7 at 128 ticks", 1);

      // R6 latency: falling edge, pin goes high then low
      pin_toggle();
      ext_pin = 1'b0;
      @(negedge clk);
      expect_tmr("R6 no change after first edge", 1);
      @(negedge clk);
      expect_tmr("R6 no change after second edge", 1);
      @(negedge clk);
      expect_tmr("R6 change after third edge", 2);
      repeat (2) @(negedge clk);

      // R2 R5 pin source, timer owner, every rate and polarity
      for (int e = 0; e < 2; e++) begin
         for (int r = 0; r < 8; r++) begin
            int p;
            p = 2 * (1 << (r + 1)) + 3;
            write_opt(mkopt(1'b1, e[0], 1'b0, r));
            write_tmr(8'h00);
            pin_pulses(p);
            expect_tmr($sformatf("R2 R5 pin edge=%0d rate=%0d", e, r), p >> (r + 1));
         end
      end

      // R2 R4 cycle source, timer owner, every rate
      for (int r = 0; r < 8; r++) begin
         int p;
         p = 3 * (1 << (r + 1)) + 1;
         write_opt(mkopt(1'b0, 1'b0, 1'b0, r));
         write_tmr(8'h00);
         tick_cyc(p);
         expect_tmr($sformatf("R2 R4 cycle rate=%0d", r), p >> (r + 1));
      end

      write_opt(mkopt(1'b0, 1'b0, 1'b0, 0));
      write_tmr(8'h07);
      pin_pulses(3);
      expect_tmr("R4 pin ignored with cycle source", 7);

      // R3 R1 watchdog owner, every rate
      for (int r = 0; r < 8; r++) begin
         int k;
         k = 3 * (1 << r) + 1;
         write_opt(mkopt(1'b0, 1'b0, 1'b1, r));
         wdt_seen = 0;
         tick_wdt(k);
         expect_wdt($sformatf("R3 watchdog rate=%0d", r), k >> r);
         write_tmr(8'h10);
         tick_cyc(5);
         expect_tmr($sformatf("R1 undivided timer rate=%0d", r), 8'h15);
      end

      // R1 timer owner: watchdog passes through, prescaler untouched
      write_opt(mkopt(1'b0, 1'b0, 1'b0, 0));
      write_tmr(8'h00);
      wdt_seen = 0;
      tick_wdt(5);
      expect_wdt("R1 timer owner watchdog undivided", 5);
      tick_cyc(1);
      expect_tmr("R1 watchdog ticks did not advance prescaler", 0);
      tick_cyc(1);
      expect_tmr("R1 second event fires divide-by-2", 1);

      // R8 hold-off window, watchdog owner, cycle source
      write_opt(mkopt(1'b0, 1'b0, 1'b1, 0));
      write_tmr_raw(8'h40);
      @(negedge clk);
      tick_cyc(1);
      expect_tmr("R8 first tick after write dropped", 8'h40);
      tick_cyc(1);
      expect_tmr("R8 second tick after write dropped", 8'h40);
      tick_cyc(1);
      expect_tmr("R8 third tick counted", 8'h41);

      // R8 prescaler cleared by a timer write (rate 1 = divide by 4)
      write_opt(mkopt(1'b0, 1'b0, 1'b0, 1));
      write_tmr(8'h00);
      tick_cyc(3);
      write_tmr(8'h20);
      tick_cyc(3);
      expect_tmr("R8 write cleared partial prescaler", 8'h20);
      tick_cyc(1);
      expect_tmr("R8 fourth event after write fires", 8'h21);

      // R10 option write clears prescaler
      write_tmr(8'h30);
      tick_cyc(3);
      write_opt(mkopt(1'b0, 1'b0, 1'b0, 1));
      tick_cyc(3);
      expect_tmr("R10 option write cleared prescaler", 8'h30);
      tick_cyc(1);
      expect_tmr("R10 fourth event after option write", 8'h31);

      // R9 wrap
      write_opt(mkopt(1'b0, 1'b0, 1'b1, 0));
      write_tmr(8'hFE);
      tick_cyc(1);
      expect_tmr("R9 reaches FFh", 8'hFF);
      tick_cyc(1);
      expect_tmr("R9 wraps to 00h", 8'h00);

      wait (q.size() == 0);
      #5;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule